// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single data line. It is paced by a one-cycle enable pulse that arrives sixteen times per bit period. A falling edge on the idle line begins a frame, and the receiver confirms that start bit half a bit later. It then collects seven or eight data bits, least significant first, into a shift stage. An optional parity bit follows, and the frame ends with a stop bit. The stop bit is judged by a majority vote of three samples around its centre.

A completed word moves from the shift stage into a holding register that the host reads. The move is announced by a one-cycle interrupt pulse. A read strobe marks the held word as consumed. Three sticky error flags report problems: overrun, parity mismatch and a bad stop bit. The flags stay set until the host pulses a clear strobe. The line input is expected to be already synchronised to the clock, and the mode inputs must stay constant while a frame is in flight.

Top module: `dual_buffer_uart_rx`

## Requirements
- R1: After reset, dataValid, rxIrq, errOverrun, errParity and errFraming are 0, and dataOut and bit9Out are 0.
- R2: A low line seen on a tick while idle starts a frame. The line is checked again on the 8th tick after that detection. If it is high there, the frame is abandoned and no word is delivered.
- R3: Data bit i is sampled 16 ticks after the sample of the bit before it. The first data bit is sampled 16 ticks after the start check. Bits arrive least significant first. In 7-bit mode (wordLen8=0), the bits land in dataOut[6:0], and dataOut[7] holds the parity bit, or 0 when parity is off. In 8-bit mode, the bits land in dataOut[7:0], and bit9Out holds the parity bit, or 0 when parity is off.
- R4: When a frame completes and the holding register is free, the word is loaded into it. dataValid becomes 1, and rxIrq is high for exactly one clock cycle.
- R5: A pulse on rdStrobe clears dataValid. dataOut and bit9Out keep the word.
- R6: When parityEn=1, the expected parity bit is the XOR of the data bits XOR parityOdd. If the received parity bit differs, errParity is set. When parityEn=0, errParity is never set.
- R7: The stop bit is sampled on the 15th, 16th and 17th ticks after the last data sample. If fewer than two of the three samples are 1, errFraming is set. The word is still delivered.
- R8: When a frame completes while dataValid=1 and rdStrobe is low, errOverrun is set. The held word is kept, the new word is dropped, no rxIrq pulse is given, and no parity check is made on the dropped word.
- R9: When rdStrobe arrives in the same cycle as a frame completion, the read is taken first. The new word is loaded, rxIrq pulses, dataValid stays 1, and errOverrun stays clear.
- R10: The error flags stay set until a pulse on clrErr, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| wordLen8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| parityEn | input | 1 | 1 = frame carries a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rdStrobe | input | 1 | Host read of the holding register |
| clrErr | input | 1 | Clears all three error flags |
| dataOut | output | 8 | Held word, bits 7..0 |
| bit9Out | output | 1 | Ninth held bit (parity in 8-bit mode) |
| dataValid | output | 1 | Holding register contains an unread word |
| rxIrq | output | 1 | One-cycle pulse when a word is loaded |
| errOverrun | output | 1 | Sticky overrun flag |
| errParity | output | 1 | Sticky parity error flag |
| errFraming | output | 1 | Sticky stop-bit error flag |

## Verification
A host read and a frame completion can fall on the same clock edge, and the outcome of that collision decides whether a word is lost or an overrun is reported. The bench provokes the collision by raising rdStrobe during the exact oversampling tick that carries the third stop-bit vote, while an older unread word is still held. It then judges the result by checking that the new word is held, that one more interrupt pulse was counted, that dataValid is still 1 and that errOverrun is still clear. The same frame is also sent without the read, and there the bench expects the overrun flag, the old word and no interrupt.

// File: rtl/rxdb_pkg.sv
package rxdb_pkg;
  parameter int MAX_BITS = 9;
  localparam int POS_W = $clog2(MAX_BITS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic             clearShift;
    logic             takeBit;
    logic [POS_W-1:0] bitPos;
    logic             takeVote;
    logic             frameDone;
  } strobes_t;
endpackage

// File: rtl/rxdb_ctrl.sv
module rxdb_ctrl #(
  parameter int OVS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick16,
  input  logic                rxd,
  input  logic                wordLen8,
  input  logic                parityEn,
  output rxdb_pkg::strobes_t  stb
);
  import rxdb_pkg::*;

  localparam int CW = $clog2(OVS + 1);
  localparam logic [CW-1:0] START_CHK = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] BIT_CHK   = CW'(OVS - 1);
  localparam logic [CW-1:0] VOTE_A    = CW'(OVS - 2);
  localparam logic [CW-1:0] VOTE_C    = CW'(OVS);

  rxState_t         state;
  logic [CW-1:0]    cnt;
  logic [POS_W-1:0] bitPos;
  logic [POS_W-1:0] lastPos;

  // frame carries 7 + wordLen8 + parityEn bits between start and stop
  assign lastPos = POS_W'(6) + POS_W'(wordLen8) + POS_W'(parityEn);

  always_comb begin
    stb = '0;
    stb.bitPos = bitPos;
    if (tick16) begin
      unique case (state)
        ST_IDLE:  stb.clearShift = !rxd;
        ST_START: stb.clearShift = 1'b0;
        ST_DATA:  stb.takeBit = (cnt == BIT_CHK);
        ST_STOP: begin
          stb.takeVote  = (cnt == VOTE_A) || (cnt == BIT_CHK);
          stb.frameDone = (cnt == VOTE_C);
        end
        default: stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitPos <= '0;
    end else if (tick16) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxd) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == START_CHK) begin
            cnt    <= '0;
            bitPos <= '0;
            state  <= rxd ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == BIT_CHK) begin
            cnt <= '0;
            if (bitPos == lastPos) state <= ST_STOP;
            else bitPos <= bitPos + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == VOTE_C) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a high line at the start check abandons the frame
  a_r2_start_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick16 && cnt == START_CHK && rxd) |=> (state == ST_IDLE));

  // R3: bits are only taken while collecting data, and never beyond the frame length
  a_r3_bit_in_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeBit |-> (state == ST_DATA && bitPos <= lastPos));

  // R7: a frame completes only from the stop phase and then returns to idle
  a_r7_done_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |=> (state == ST_IDLE));
endmodule

// File: rtl/rxdb_path.sv
module rxdb_path (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxd,
  input  logic               wordLen8,
  input  logic               parityEn,
  input  logic               parityOdd,
  input  logic               rdStrobe,
  input  logic               clrErr,
  input  rxdb_pkg::strobes_t stb,
  output logic [7:0]         dataOut,
  output logic               bit9Out,
  output logic               dataValid,
  output logic               rxIrq,
  output logic               errOverrun,
  output logic               errParity,
  output logic               errFraming
);
  import rxdb_pkg::*;

  logic [MAX_BITS-1:0] shiftReg;
  logic [MAX_BITS-1:0] holdReg;
  logic [1:0]          votes;
  logic                stopGood;
  logic                loadNow;
  logic                ovrSet;
  logic                parSet;
  logic                frmSet;
  logic [7:0]          dataBits;
  logic                rxParity;
  logic                wantParity;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      votes    <= '0;
    end else begin
      if (stb.clearShift) shiftReg <= '0;
      for (int i = 0; i < MAX_BITS; i++) begin
        if (stb.takeBit && stb.bitPos == POS_W'(i)) shiftReg[i] <= rxd;
      end
      if (stb.takeVote) votes <= {votes[0], rxd};
    end
  end

  assign stopGood = (votes[0] & votes[1]) | (votes[0] & rxd) | (votes[1] & rxd);

  always_comb begin
    if (wordLen8) begin
      dataBits = shiftReg[7:0];
      rxParity = shiftReg[8];
    end else begin
      dataBits = {1'b0, shiftReg[6:0]};
      rxParity = shiftReg[7];
    end
  end

  assign wantParity = (^dataBits) ^ parityOdd;
  assign loadNow    = stb.frameDone && (!dataValid || rdStrobe);
  assign ovrSet     = stb.frameDone && dataValid && !rdStrobe;
  assign parSet     = loadNow && parityEn && (rxParity != wantParity);
  assign frmSet     = stb.frameDone && !stopGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg    <= '0;
      dataValid  <= 1'b0;
      rxIrq      <= 1'b0;
      errOverrun <= 1'b0;
      errParity  <= 1'b0;
      errFraming <= 1'b0;
    end else begin
      rxIrq <= loadNow;
      if (loadNow) begin
        holdReg   <= shiftReg;
        dataValid <= 1'b1;
      end else if (rdStrobe) begin
        dataValid <= 1'b0;
      end
      errOverrun <= (errOverrun & ~clrErr) | ovrSet;
      errParity  <= (errParity & ~clrErr) | parSet;
      errFraming <= (errFraming & ~clrErr) | frmSet;
    end
  end

  assign dataOut = holdReg[7:0];
  assign bit9Out = holdReg[8];

  // R4: the interrupt pulse always coincides with a held word
  a_r4_irq_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> dataValid);

  // R4: the interrupt is a single-cycle pulse
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  // R5: a read with no load in the same cycle frees the holding register
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !stb.frameDone) |=> !dataValid);

  // R8: an overrun keeps the old word and raises the flag
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameDone && dataValid && !rdStrobe) |=> ($stable(holdReg) && errOverrun && !rxIrq));

  // R9: a read in the completion cycle lets the new word in without overrun
  a_r9_read_and_load: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameDone && dataValid && rdStrobe && !errOverrun && !clrErr) |=> (dataValid && rxIrq && !errOverrun));

  // R10: flags hold without a clear strobe
  a_r10_sticky_par: assert property (@(posedge clk) disable iff (!rstN)
    (errParity && !clrErr) |=> errParity);
  a_r10_sticky_frm: assert property (@(posedge clk) disable iff (!rstN)
    (errFraming && !clrErr) |=> errFraming);
endmodule

// File: rtl/dual_buffer_uart_rx.sv
module dual_buffer_uart_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       wordLen8,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       rdStrobe,
  input  logic       clrErr,
  output logic [7:0] dataOut,
  output logic       bit9Out,
  output logic       dataValid,
  output logic       rxIrq,
  output logic       errOverrun,
  output logic       errParity,
  output logic       errFraming
);
  rxdb_pkg::strobes_t stb;

  rxdb_ctrl #(.OVS(OVS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .rxd      (rxd),
    .wordLen8 (wordLen8),
    .parityEn (parityEn),
    .stb      (stb)
  );

  rxdb_path i_path (
    .clk        (clk),
    .rstN       (rstN),
    .rxd        (rxd),
    .wordLen8   (wordLen8),
    .parityEn   (parityEn),
    .parityOdd  (parityOdd),
    .rdStrobe   (rdStrobe),
    .clrErr     (clrErr),
    .stb        (stb),
    .dataOut    (dataOut),
    .bit9Out    (bit9Out),
    .dataValid  (dataValid),
    .rxIrq      (rxIrq),
    .errOverrun (errOverrun),
    .errParity  (errParity),
    .errFraming (errFraming)
  );
endmodule

// File: tb/test_dual_buffer_uart_rx.sv
`timescale 1ns/1ps
module test_dual_buffer_uart_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic wordLen8 = 1'b0;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic rdStrobe = 1'b0;
  logic clrErr = 1'b0;
  logic [7:0] dataOut;
  logic bit9Out, dataValid, rxIrq, errOverrun, errParity, errFraming;

  int total = 0;
  int bad = 0;
  int irqCnt = 0;
  int tickGap = 1;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_buffer_uart_rx i_dual_buffer_uart_rx (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxd(rxd),
    .wordLen8(wordLen8), .parityEn(parityEn), .parityOdd(parityOdd),
    .rdStrobe(rdStrobe), .clrErr(clrErr),
    .dataOut(dataOut), .bit9Out(bit9Out), .dataValid(dataValid), .rxIrq(rxIrq),
    .errOverrun(errOverrun), .errParity(errParity), .errFraming(errFraming)
  );

  always @(negedge clk) begin
    cycles++;
    if (rxIrq) irqCnt++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one oversampling period with the line held at v
  task automatic oneTick(input logic v, input logic rd);
    @(negedge clk);
    rxd = v;
    tick16 = 1'b1;
    rdStrobe = rd;
    @(negedge clk);
    tick16 = 1'b0;
    rdStrobe = 1'b0;
    for (int g = 1; g < tickGap; g++) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] bits, input int nb,
                           input logic [2:0] votes, input logic rdAtEnd);
    for (int t = 0; t < 16; t++) oneTick(1'b0, 1'b0);
    for (int i = 0; i < nb; i++)
      for (int t = 0; t < 16; t++) oneTick(bits[i], 1'b0);
    for (int t = 0; t < 16; t++) begin
      if (t == 7) oneTick(votes[0], 1'b0);
      else if (t == 8) oneTick(votes[1], 1'b0);
      else if (t == 9) oneTick(votes[2], rdAtEnd);
      else oneTick(1'b1, 1'b0);
    end
    oneTick(1'b1, 1'b0);
    oneTick(1'b1, 1'b0);
  endtask

  task automatic pulseRead();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); clrErr = 1'b1;
    @(negedge clk); clrErr = 1'b0;
  endtask

  // frame bits for a data value under the current mode; flip corrupts parity
  function automatic logic [8:0] makeBits(input logic [7:0] d, input logic flip);
    logic [7:0] dm;
    logic p;
    dm = wordLen8 ? d : {1'b0, d[6:0]};
    p = (^dm) ^ parityOdd ^ flip;
    makeBits = {1'b0, dm};
    if (parityEn) begin
      if (wordLen8) makeBits[8] = p;
      else makeBits[7] = p;
    end
  endfunction

  function automatic int frameLen();
    frameLen = 7 + int'(wordLen8) + int'(parityEn);
  endfunction

  initial begin
    logic [8:0] bits;
    logic [8:0] oldBits;
    int irqBefore;

    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, dataValid}, 0);
    chk("R1 reset irq", {31'b0, rxIrq}, 0);
    chk("R1 reset flags", {29'b0, errOverrun, errParity, errFraming}, 0);
    chk("R1 reset data", {23'b0, bit9Out, dataOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // sweep all modes with several data patterns (R3 R4 R5 R6)
    for (int cfg = 0; cfg < 8; cfg++) begin
      wordLen8 = cfg[0];
      parityEn = cfg[1];
      parityOdd = cfg[2];
      for (int v = 0; v < 32; v++) begin
        logic flip;
        logic [7:0] d;
        d = 8'((v * 37 + cfg * 11 + (v >> 3) * 128) & 255);
        flip = parityEn && (v % 4 == 3);
        bits = makeBits(d, flip);
        irqBefore = irqCnt;
        sendFrame(bits, frameLen(), 3'b111, 1'b0);
        chk("R4 irq once", irqCnt - irqBefore, 1);
        chk("R4 valid", {31'b0, dataValid}, 1);
        chk("R3 word", {23'b0, bit9Out, dataOut}, {23'b0, bits});
        chk("R6 parity flag", {31'b0, errParity}, {31'b0, flip});
        chk("R7 no framing", {31'b0, errFraming}, 0);
        pulseRead();
        @(negedge clk);
        chk("R5 valid cleared", {31'b0, dataValid}, 0);
        chk("R5 word kept", {23'b0, bit9Out, dataOut}, {23'b0, bits});
        if (flip) begin
          @(negedge clk);
          chk("R10 still set", {31'b0, errParity}, 1);
          pulseClr();
          @(negedge clk);
          chk("R10 cleared", {31'b0, errParity}, 0);
        end
      end
    end

    // slower tick pacing
    tickGap = 3;
    wordLen8 = 1'b1; parityEn = 1'b1; parityOdd = 1'b1;
    bits = makeBits(8'hA5, 1'b0);
    sendFrame(bits, frameLen(), 3'b111, 1'b0);
    chk("R3 word slow tick", {23'b0, bit9Out, dataOut}, {23'b0, bits});
    chk("R6 slow no error", {31'b0, errParity}, 0);
    pulseRead();
    tickGap = 1;

    // R2: aborted start produces nothing
    irqBefore = irqCnt;
    for (int t = 0; t < 5; t++) oneTick(1'b0, 1'b0);
    for (int t = 0; t < 40; t++) oneTick(1'b1, 1'b0);
    chk("R2 abort no irq", irqCnt - irqBefore, 0);
    chk("R2 abort no valid", {31'b0, dataValid}, 0);
    bits = makeBits(8'h3C, 1'b0);
    sendFrame(bits, frameLen(), 3'b111, 1'b0);
    chk("R2 next frame ok", {23'b0, bit9Out, dataOut}, {23'b0, bits});
    pulseRead();

    // R7: every vote pattern
    wordLen8 = 1'b0; parityEn = 1'b0; parityOdd = 1'b0;
    for (int vp = 0; vp < 8; vp++) begin
      logic [2:0] vv;
      logic expF;
      vv = 3'(vp);
      expF = ($countones(vv) < 2);
      bits = makeBits(8'(vp * 17 + 5), 1'b0);
      irqBefore = irqCnt;
      sendFrame(bits, frameLen(), vv, 1'b0);
      chk("R7 framing vote", {31'b0, errFraming}, {31'b0, expF});
      chk("R7 word delivered", {23'b0, bit9Out, dataOut}, {23'b0, bits});
      chk("R7 irq", irqCnt - irqBefore, 1);
      pulseRead();
      pulseClr();
      @(negedge clk);
      chk("R10 framing cleared", {31'b0, errFraming}, 0);
    end

    // R8: overrun keeps the old word, no parity check on dropped word
    wordLen8 = 1'b1; parityEn = 1'b1; parityOdd = 1'b0;
    oldBits = makeBits(8'h5A, 1'b0);
    sendFrame(oldBits, frameLen(), 3'b111, 1'b0);
    irqBefore = irqCnt;
    bits = makeBits(8'hC3, 1'b1);
    sendFrame(bits, frameLen(), 3'b111, 1'b0);
    chk("R8 overrun flag", {31'b0, errOverrun}, 1);
    chk("R8 old word kept", {23'b0, bit9Out, dataOut}, {23'b0, oldBits});
    chk("R8 no irq", irqCnt - irqBefore, 0);
    chk("R8 no parity on dropped", {31'b0, errParity}, 0);
    chk("R8 still valid", {31'b0, dataValid}, 1);
    repeat (4) @(negedge clk);
    chk("R10 overrun sticky", {31'b0, errOverrun}, 1);
    pulseClr();
    @(negedge clk);
    chk("R10 overrun cleared", {31'b0, errOverrun}, 0);

    // R9: read coincides with completion while old word is held
    irqBefore = irqCnt;
    bits = makeBits(8'h81, 1'b0);
    sendFrame(bits, frameLen(), 3'b111, 1'b1);
    chk("R9 no overrun", {31'b0, errOverrun}, 0);
    chk("R9 new word", {23'b0, bit9Out, dataOut}, {23'b0, bits});
    chk("R9 irq", irqCnt - irqBefore, 1);
    chk("R9 valid", {31'b0, dataValid}, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule